// File: doc/BRIEF.md
# Snoop Response Combiner and Data Source Selector

This block sits beside a shared snooping bus and settles every bus transaction once all caches have looked up their tags. Each of the N caches drives three lines: it holds the line, it holds the line dirty, and its lookup has not finished yet. The block merges each kind across all caches as an OR. It waits as long as any lookup is still running, so caches may take a different number of cycles on each transaction. Once every lookup has finished, it picks the source of the data. Memory supplies the data when no cache holds a dirty copy. Otherwise the single cache holding the dirty copy supplies it.

Along with the decision, the block returns a shared indication to the requester, so the requester can fill its line as clean-exclusive or as shared. Upgrade requests need no data, so they finish with no supplier selected. Two faults are reported: more than one cache claiming a dirty copy, and lookups that run past a configured number of cycles. Only one transaction is in flight at a time.

Top module: `snoop_resp_combiner`

## Requirements
- R1: After reset, `done`, `mem_respond`, `supply_grant`, `shared_out`, `proto_err` and `timeout_err` are all low.
- R2: A request is accepted on a clock edge when `req_valid` is high and no transaction is open. After acceptance, the snoop vectors are sampled on the first edge at which no bit of `snoop_busy` is set. The results appear in the following cycle, as a one-cycle `done` pulse. For a read (any `req_type` other than 2'b10) with no dirty copy reported, `mem_respond` pulses together with `done` and `supply_grant` stays zero.
- R3: While any bit of `snoop_busy` is set, `done`, `mem_respond` and `supply_grant` stay low, whatever the number of cycles the lookups take.
- R4: For a read where exactly one bit of `snoop_mod` is set, `supply_grant` pulses with `done` and equals that one-hot vector, and `mem_respond` stays low.
- R5: At `done`, `shared_out` is the OR of all `snoop_copy` and `snoop_mod` bits that were sampled.
- R6: An upgrade (`req_type` 2'b10) completes with `done` while `mem_respond` and `supply_grant` stay low.
- R7: When more than one `snoop_mod` bit is set at sampling, `proto_err` pulses with `done`, and neither `mem_respond` nor `supply_grant` is raised.
- R8: `snoop_busy` may stay nonzero for up to `TIMEOUT_CYCLES` consecutive sampled edges after acceptance and the transaction still completes normally. On the next consecutive busy edge, the transaction ends with `done` and `timeout_err`, and neither `mem_respond` nor `supply_grant` is raised.
- R9: `req_valid` is ignored while a transaction is open, so each accepted request produces exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_type | input | 2 | 00 read shared, 01 read exclusive, 10 upgrade, 11 read |
| snoop_copy | input | NUM_CACHES | Per-cache holds-line flag |
| snoop_mod | input | NUM_CACHES | Per-cache holds-dirty-line flag |
| snoop_busy | input | NUM_CACHES | Per-cache lookup-not-finished flag |
| mem_respond | output | 1 | Memory should supply the data |
| supply_grant | output | NUM_CACHES | One-hot cache chosen to supply the data |
| shared_out | output | 1 | Some other cache keeps a copy |
| done | output | 1 | Transaction result valid, one cycle |
| proto_err | output | 1 | Several dirty owners reported |
| timeout_err | output | 1 | Lookups exceeded the allowed cycles |

## Verification
Read requests are driven with no sharer, with clean sharers only, and with a single dirty owner in both the lowest and the highest cache slot. These cases separate the memory-supply, shared-fill and cache-supply decisions, and they show that the grant index follows the owner. Lookup latency is varied between zero cycles, a few cycles on one cache and exactly the timeout limit, so a design that samples at a fixed cycle is caught. One more busy cycle past the limit shows that the timeout boundary is not off by one. Upgrades with a dirty owner present, double owners, and a second request pulsed mid-transaction check that each case is told apart from a normal read.

// File: rtl/sr_pkg.sv
package sr_pkg;

    typedef enum logic [1:0] {
        REQ_RD_SHARED = 2'b00,
        REQ_RD_EXCL   = 2'b01,
        REQ_UPGRADE   = 2'b10,
        REQ_RD_OTHER  = 2'b11
    } req_kind_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

endpackage

// File: rtl/sr_or_merge.sv
module sr_or_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] copy_vec,
    input  logic [N-1:0] mod_vec,
    input  logic [N-1:0] busy_vec,
    output logic         any_copy,
    output logic         any_mod,
    output logic         any_busy,
    output logic         multi_mod
);

    logic [N:0]   seen;
    logic [N-1:0] dup;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_scan
            assign seen[i+1] = seen[i] | mod_vec[i];
            assign dup[i]    = seen[i] & mod_vec[i];
        end
    endgenerate

    assign any_copy  = |copy_vec;
    assign any_mod   = seen[N];
    assign any_busy  = |busy_vec;
    assign multi_mod = |dup;

endmodule

// File: rtl/sr_wait_timer.sv
module sr_wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic count_en,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (count_en && !expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/snoop_resp_combiner.sv
module snoop_resp_combiner
    import sr_pkg::*;
#(
    parameter int NUM_CACHES     = 4,
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_type,
    input  logic [NUM_CACHES-1:0] snoop_copy,
    input  logic [NUM_CACHES-1:0] snoop_mod,
    input  logic [NUM_CACHES-1:0] snoop_busy,
    output logic                  mem_respond,
    output logic [NUM_CACHES-1:0] supply_grant,
    output logic                  shared_out,
    output logic                  done,
    output logic                  proto_err,
    output logic                  timeout_err
);

    typedef struct packed {
        phase_e                phase;
        logic                  is_upg;
        logic                  done;
        logic                  mem;
        logic [NUM_CACHES-1:0] grant;
        logic                  shared;
        logic                  perr;
        logic                  terr;
    } ctl_t;

    ctl_t st_d, st_q;

    logic any_copy, any_mod, any_busy, multi_mod;
    logic tmr_clear, tmr_expired;

    sr_or_merge #(.N(NUM_CACHES)) u_merge (
        .copy_vec  (snoop_copy),
        .mod_vec   (snoop_mod),
        .busy_vec  (snoop_busy),
        .any_copy  (any_copy),
        .any_mod   (any_mod),
        .any_busy  (any_busy),
        .multi_mod (multi_mod)
    );

    sr_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tmr_clear),
        .count_en (any_busy && (st_q.phase == PH_WAIT)),
        .expired  (tmr_expired)
    );

    always_comb begin
        st_d        = st_q;
        st_d.done   = 1'b0;
        st_d.mem    = 1'b0;
        st_d.grant  = '0;
        st_d.shared = 1'b0;
        st_d.perr   = 1'b0;
        st_d.terr   = 1'b0;
        tmr_clear   = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase  = PH_WAIT;
                    st_d.is_upg = (req_kind_e'(req_type) == REQ_UPGRADE);
                    tmr_clear   = 1'b1;
                end
            end
            PH_WAIT: begin
                if (!any_busy) begin
                    st_d.phase  = PH_IDLE;
                    st_d.done   = 1'b1;
                    st_d.shared = any_copy | any_mod;
                    if (multi_mod) begin
                        st_d.perr = 1'b1;
                    end else if (!st_q.is_upg) begin
                        if (any_mod) begin
                            st_d.grant = snoop_mod;
                        end else begin
                            st_d.mem = 1'b1;
                        end
                    end
                end else if (tmr_expired) begin
                    st_d.phase = PH_IDLE;
                    st_d.done  = 1'b1;
                    st_d.terr  = 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_respond  = st_q.mem;
    assign supply_grant = st_q.grant;
    assign shared_out   = st_q.shared;
    assign done         = st_q.done;
    assign proto_err    = st_q.perr;
    assign timeout_err  = st_q.terr;

endmodule

// File: rtl/sr_checker.sv
module sr_checker #(
    parameter int NUM_CACHES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [1:0]            req_type,
    input logic [NUM_CACHES-1:0] snoop_busy,
    input logic                  mem_respond,
    input logic [NUM_CACHES-1:0] supply_grant,
    input logic                  done,
    input logic                  proto_err,
    input logic                  timeout_err
);

    logic open_q, upg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            upg_q  <= 1'b0;
        end else if (done) begin
            open_q <= req_valid;
            upg_q  <= req_valid && (req_type == 2'b10);
        end else if (req_valid && !open_q) begin
            open_q <= 1'b1;
            upg_q  <= (req_type == 2'b10);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(supply_grant)); // R4

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_respond && (supply_grant != '0))); // R4

    AST_RESULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_respond || (supply_grant != '0) || proto_err || timeout_err) |-> done); // R2

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !timeout_err) |-> ($past(snoop_busy) == '0)); // R3

    AST_UPG_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (done && upg_q) |-> (!mem_respond && (supply_grant == '0))); // R6

    AST_PERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!mem_respond && (supply_grant == '0))); // R7

    AST_TERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (!mem_respond && (supply_grant == '0))); // R8

    AST_DONE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> open_q); // R9

endmodule

bind snoop_resp_combiner sr_checker #(.NUM_CACHES(NUM_CACHES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_type     (req_type),
    .snoop_busy   (snoop_busy),
    .mem_respond  (mem_respond),
    .supply_grant (supply_grant),
    .done         (done),
    .proto_err    (proto_err),
    .timeout_err  (timeout_err)
);

// File: tb/snoop_resp_combiner_tb.sv
`timescale 1ns/1ps
module snoop_resp_combiner_tb;

    localparam int NC  = 4;
    localparam int LIM = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_type = 2'b00;
    logic [NC-1:0] snoop_copy = '0;
    logic [NC-1:0] snoop_mod = '0;
    logic [NC-1:0] snoop_busy = '0;
    logic          mem_respond;
    logic [NC-1:0] supply_grant;
    logic          shared_out;
    logic          done;
    logic          proto_err;
    logic          timeout_err;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    snoop_resp_combiner #(.NUM_CACHES(NC), .TIMEOUT_CYCLES(LIM)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_type     (req_type),
        .snoop_copy   (snoop_copy),
        .snoop_mod    (snoop_mod),
        .snoop_busy   (snoop_busy),
        .mem_respond  (mem_respond),
        .supply_grant (supply_grant),
        .shared_out   (shared_out),
        .done         (done),
        .proto_err    (proto_err),
        .timeout_err  (timeout_err)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Issue one request; hold busy for busy_cyc edges, then release and check results.
    task automatic run_txn(input string req, input logic [1:0] kind, input int busy_cyc,
                           input logic [NC-1:0] copy, input logic [NC-1:0] modv,
                           input logic exp_mem, input logic [NC-1:0] exp_grant,
                           input logic exp_perr);
        bit early = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_type  = kind;
        @(negedge clk);
        req_valid  = 1'b0;
        snoop_copy = copy;
        snoop_mod  = modv;
        snoop_busy = (busy_cyc > 0) ? 4'b0100 : '0;
        for (int i = 0; i < busy_cyc; i++) begin
            @(negedge clk);
            if (done || mem_respond || supply_grant != '0) early = 1;
        end
        snoop_busy = '0;
        check("R3", "output before lookups finished", 32'(early), 32'd0);
        @(negedge clk);
        check(req, "done", 32'(done), 32'd1);
        check(req, "mem_respond", 32'(mem_respond), 32'(exp_mem));
        check(req, "supply_grant", 32'(supply_grant), 32'(exp_grant));
        check("R5", "shared_out", 32'(shared_out), 32'((|copy) | (|modv)));
        check(req, "proto_err", 32'(proto_err), 32'(exp_perr));
        check(req, "timeout_err", 32'(timeout_err), 32'd0);
        snoop_copy = '0;
        snoop_mod  = '0;
        @(negedge clk);
        check(req, "done is one cycle", 32'(done), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "outputs in reset",
              {26'd0, done, mem_respond, shared_out, proto_err, timeout_err, |supply_grant}, 32'd0);
    endtask

    task automatic t_timeout();
        bit early = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_type  = 2'b00;
        @(negedge clk);
        req_valid  = 1'b0;
        snoop_busy = 4'b0001;
        snoop_mod  = 4'b0010;
        for (int i = 0; i < LIM; i++) begin
            @(negedge clk);
            if (done) early = 1;
        end
        check("R8", "no done within limit", 32'(early), 32'd0);
        @(negedge clk);
        check("R8", "done at timeout", 32'(done), 32'd1);
        check("R8", "timeout_err", 32'(timeout_err), 32'd1);
        check("R8", "no supplier on timeout", 32'({mem_respond, supply_grant}), 32'd0);
        snoop_busy = '0;
        snoop_mod  = '0;
        @(negedge clk);
        check("R8", "no late done", 32'(done), 32'd0);
    endtask

    task automatic t_overlap();
        int dones = 0;
        bit saw_mem = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_type  = 2'b01;
        @(negedge clk);
        req_type   = 2'b10;
        snoop_busy = 4'b1000;
        for (int i = 0; i < 3; i++) @(negedge clk);
        req_valid  = 1'b0;
        snoop_busy = '0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (done) dones++;
            if (mem_respond) saw_mem = 1;
        end
        check("R9", "single done for overlapped request", 32'(dones), 32'd1);
        check("R9", "first request kept its read kind", 32'(saw_mem), 32'd1);
    endtask

    initial begin
        #(200000 * 4);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        run_txn("R2", 2'b00, 0, 4'b0000, 4'b0000, 1'b1, 4'b0000, 1'b0);
        run_txn("R2", 2'b01, 3, 4'b0110, 4'b0000, 1'b1, 4'b0000, 1'b0);
        run_txn("R4", 2'b00, 2, 4'b0001, 4'b1000, 1'b0, 4'b1000, 1'b0);
        run_txn("R4", 2'b11, 0, 4'b0000, 4'b0001, 1'b0, 4'b0001, 1'b0);
        run_txn("R6", 2'b10, 1, 4'b0010, 4'b0100, 1'b0, 4'b0000, 1'b0);
        run_txn("R7", 2'b00, 0, 4'b0000, 4'b0101, 1'b0, 4'b0000, 1'b1);
        run_txn("R8", 2'b00, LIM, 4'b1000, 4'b0000, 1'b1, 4'b0000, 1'b0);
        t_timeout();
        t_overlap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule